// File: doc/BRIEF.md
# Interrupt Priority and Mask Controller

This block decides which interrupt request a small 8-bit processor core takes next. It has sixteen inputs. One active-low external pin can sense either a low level or a falling edge. One active-low pin is non-maskable once enabled. Fourteen active-high peripheral lines are synchronous to the core clock. The pin and the fourteen lines are the fifteen maskable sources. The core supplies its global interrupt mask bit. The block holds three things: the enable state of the non-maskable pin, a sense-mode bit for the external pin, and a 4-bit code that lifts one maskable source to the top of the maskable order.

A two-state machine handles the offers. In `ST_IDLE` the block watches the arbiter. On the first clock edge where a winner exists it takes the transition "grant" to `ST_OFFER`. In that edge it latches the winner's index and vector address. In `ST_OFFER` it raises the take strobe and holds the index and vector until the core pulses the acknowledge. It then takes the transition "ack" back to `ST_IDLE`. The block always spends at least one cycle in `ST_IDLE` before it can make another offer. An acknowledge of the external pin's offer also clears that pin's edge latch.

The core writes the sense bit, the promotion code and the non-maskable enable through three write strobes. Instruction execution and register stacking are left to the core.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `int_take` is 0. The non-maskable pin is disabled, the promotion code is 0 (the external pin) and the external pin is level-sensed.
- R2: While `core_imask` is 1, no maskable source is offered and its request stays pending. Once `core_imask` is 0, a pending maskable request is offered.
- R3: Each maskable source has a code. Code 0 is the external pin and code k+1 is `periph_req[k]`. With no promotion in force, the lowest pending code wins.
- R4: A `prio_we` write while `core_imask` is 1 stores `prio_wdata`. A pending source whose code equals the stored value then beats every other maskable source. The value 15 promotes nothing.
- R5: A `prio_we` write while `core_imask` is 0 is ignored and the old promotion code stays in force.
- R6: A write of `sense_wdata` through `sense_we` sets the external pin's mode. The value 0 selects low-level sensing and 1 selects falling-edge sensing. In the core's 8-bit option register this is bit 5. In level mode the pin is pending only while its synchronized value is low.
- R7: In edge mode, a falling edge of the synchronized pin latches a pending flag. The flag stays set after the pin returns high. It is cleared only when an offer with index 0 is acknowledged.
- R8: The non-maskable pin is ignored until an `xmask_we` write with `xmask_wdata` = 0 enables it. Later writes with `xmask_wdata` = 1 do not disable it again.
- R9: When the non-maskable pin is enabled and low, it is offered with index 15. This happens whatever the value of `core_imask`, and it wins over every maskable source.
- R10: The vector is 0xFFF4 for index 15 and 0xFFF2 for index 0. For code m from 1 to 14 the vector is 0xFFF0 − 2·m.
- R11: `int_take` stays 1 with a stable `int_idx` and `int_vector` until `int_ack`. In the cycle after the acknowledge, `int_take` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | External maskable request pin, active low, asynchronous |
| xirq_n | input | 1 | Non-maskable request pin, active low, asynchronous |
| periph_req | input | 14 | Peripheral requests, active high, synchronous; bit k is code k+1 |
| core_imask | input | 1 | Global maskable-interrupt mask from the core |
| sense_we | input | 1 | Write strobe for the pin sense mode |
| sense_wdata | input | 1 | Sense mode: 0 level, 1 falling edge |
| prio_we | input | 1 | Write strobe for the promotion code |
| prio_wdata | input | 4 | Promotion code |
| xmask_we | input | 1 | Write strobe for the non-maskable enable |
| xmask_wdata | input | 1 | 0 enables the non-maskable pin; 1 has no effect |
| int_ack | input | 1 | Core acknowledge of the current offer (vector fetch) |
| int_take | output | 1 | An offer is pending for the core |
| int_idx | output | 4 | Index of the offered source (15 = non-maskable) |
| int_vector | output | 16 | Vector address of the offered source |

## Verification
The assertions assume that the core raises `int_ack` only while `int_take` is 1, and for one cycle at a time. They also assume that `periph_req`, `core_imask` and the write strobes are synchronous to `clk`. The bench drives every input on the falling edge. It raises the acknowledge only after it has seen the take strobe. At the same falling edge it sets `core_imask` to 1, as a core entering a handler would. This keeps any level-held request from being offered a second time unless the test asks for it.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int          NUM_MASKABLE = 15;
    localparam int          IDX_W        = 4;
    localparam int          VEC_W        = 16;
    localparam logic [IDX_W-1:0] IDX_NMI  = 4'd15;
    localparam logic [IDX_W-1:0] IDX_PIN  = 4'd0;
    localparam logic [VEC_W-1:0] VEC_NMI  = 16'hFFF4;
    localparam logic [VEC_W-1:0] VEC_PIN  = 16'hFFF2;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'hFFF0;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } offer_state_t;

    function automatic logic [VEC_W-1:0] vector_of(input logic [IDX_W-1:0] idx);
        if (idx == IDX_NMI)
            return VEC_NMI;
        else if (idx == IDX_PIN)
            return VEC_PIN;
        else
            return VEC_BASE - {{(VEC_W-IDX_W-1){1'b0}}, idx, 1'b0};
    endfunction
endpackage

// File: rtl/irq_sense.sv
module irq_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    input  logic xirq_n,
    input  logic edge_mode,
    input  logic pin_clr,
    output logic pin_pend,
    output logic nmi_low
);
    logic [SYNC_STAGES-1:0] pin_sync;
    logic [SYNC_STAGES-1:0] nmi_sync;
    logic                   pin_last;
    logic                   edge_flag;
    logic                   pin_lvl;
    logic                   pin_fall;

    assign pin_lvl  = pin_sync[SYNC_STAGES-1];
    assign pin_fall = pin_last & ~pin_lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_sync <= '1;
            nmi_sync <= '1;
            pin_last <= 1'b1;
        end else begin
            pin_sync <= {pin_sync[SYNC_STAGES-2:0], irq_n};
            nmi_sync <= {nmi_sync[SYNC_STAGES-2:0], xirq_n};
            pin_last <= pin_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            edge_flag <= 1'b0;
        else if (!edge_mode)
            edge_flag <= 1'b0;
        else if (pin_fall)
            edge_flag <= 1'b1;
        else if (pin_clr)
            edge_flag <= 1'b0;
    end

    assign pin_pend = edge_mode ? edge_flag : ~pin_lvl;
    assign nmi_low  = ~nmi_sync[SYNC_STAGES-1];

    // R7
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && pin_fall) |=> edge_flag);

    // R6
    level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> !edge_flag);
endmodule

// File: rtl/irq_cfg.sv
module irq_cfg
    import irq_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_imask,
    input  logic             sense_we,
    input  logic             sense_wdata,
    input  logic             prio_we,
    input  logic [IDX_W-1:0] prio_wdata,
    input  logic             xmask_we,
    input  logic             xmask_wdata,
    output logic             edge_mode,
    output logic [IDX_W-1:0] prio_sel,
    output logic             nmi_masked
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_mode  <= 1'b0;
            prio_sel   <= IDX_PIN;
            nmi_masked <= 1'b1;
        end else begin
            if (sense_we)
                edge_mode <= sense_wdata;
            if (prio_we && core_imask)
                prio_sel <= prio_wdata;
            if (xmask_we && !xmask_wdata)
                nmi_masked <= 1'b0;
        end
    end

    // R8
    nmi_mask_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(nmi_masked));

    // R5
    prio_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_imask |=> $stable(prio_sel));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_prio_pkg::*;
(
    input  logic [NUM_MASKABLE-1:0] mask_req,
    input  logic                    nmi_req,
    input  logic                    core_imask,
    input  logic [IDX_W-1:0]        prio_sel,
    output logic                    win_valid,
    output logic [IDX_W-1:0]        win_idx
);
    logic [NUM_MASKABLE:0] req_ext;
    logic [IDX_W-1:0]      lowest;
    logic                  any_mask;

    assign req_ext  = {1'b0, mask_req};
    assign any_mask = |mask_req;

    always_comb begin
        lowest = '0;
        for (int k = NUM_MASKABLE - 1; k >= 0; k--) begin
            if (mask_req[k])
                lowest = IDX_W'(k);
        end
    end

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        if (nmi_req) begin
            win_valid = 1'b1;
            win_idx   = IDX_NMI;
        end else if (!core_imask && any_mask) begin
            win_valid = 1'b1;
            win_idx   = req_ext[prio_sel] ? prio_sel : lowest;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    irq_n,
    input  logic                    xirq_n,
    input  logic [NUM_MASKABLE-2:0] periph_req,
    input  logic                    core_imask,
    input  logic                    sense_we,
    input  logic                    sense_wdata,
    input  logic                    prio_we,
    input  logic [IDX_W-1:0]        prio_wdata,
    input  logic                    xmask_we,
    input  logic                    xmask_wdata,
    input  logic                    int_ack,
    output logic                    int_take,
    output logic [IDX_W-1:0]        int_idx,
    output logic [VEC_W-1:0]        int_vector
);
    offer_state_t     state_q;
    logic [IDX_W-1:0] idx_q;
    logic [VEC_W-1:0] vec_q;
    logic             edge_mode;
    logic [IDX_W-1:0] prio_sel;
    logic             nmi_masked;
    logic             pin_pend;
    logic             nmi_low;
    logic             nmi_req;
    logic             pin_clr;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;

    irq_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_imask  (core_imask),
        .sense_we    (sense_we),
        .sense_wdata (sense_wdata),
        .prio_we     (prio_we),
        .prio_wdata  (prio_wdata),
        .xmask_we    (xmask_we),
        .xmask_wdata (xmask_wdata),
        .edge_mode   (edge_mode),
        .prio_sel    (prio_sel),
        .nmi_masked  (nmi_masked)
    );

    irq_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_n     (irq_n),
        .xirq_n    (xirq_n),
        .edge_mode (edge_mode),
        .pin_clr   (pin_clr),
        .pin_pend  (pin_pend),
        .nmi_low   (nmi_low)
    );

    assign nmi_req = nmi_low & ~nmi_masked;

    irq_arbiter u_arb (
        .mask_req   ({periph_req, pin_pend}),
        .nmi_req    (nmi_req),
        .core_imask (core_imask),
        .prio_sel   (prio_sel),
        .win_valid  (win_valid),
        .win_idx    (win_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (win_valid) state_q <= ST_OFFER;
                ST_OFFER: if (int_ack)   state_q <= ST_IDLE;
                default:                 state_q <= ST_IDLE;
            endcase
        end
    end

    // Offer contents, captured on the grant transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            vec_q <= '0;
        end else if (state_q == ST_IDLE && win_valid) begin
            idx_q <= win_idx;
            vec_q <= vector_of(win_idx);
        end
    end

    assign pin_clr    = (state_q == ST_OFFER) && int_ack && (idx_q == IDX_PIN);
    assign int_take   = (state_q == ST_OFFER);
    assign int_idx    = idx_q;
    assign int_vector = vec_q;

    // R11
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_take && !int_ack) |=> (int_take && $stable(int_idx) && $stable(int_vector)));

    // R11
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_take && int_ack) |=> !int_take);

    // R2
    mask_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_take) && int_idx != IDX_NMI) |-> !$past(core_imask));

    // R9
    nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_take) && $past(nmi_req)) |-> int_idx == IDX_NMI);

    // R10
    pin_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_take && int_idx == IDX_PIN) |-> int_vector == VEC_PIN);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_n = 1'b1;
    logic        xirq_n = 1'b1;
    logic [13:0] periph_req = '0;
    logic        core_imask = 1'b1;
    logic        sense_we = 1'b0;
    logic        sense_wdata = 1'b0;
    logic        prio_we = 1'b0;
    logic [3:0]  prio_wdata = '0;
    logic        xmask_we = 1'b0;
    logic        xmask_wdata = 1'b1;
    logic        int_ack = 1'b0;
    logic        int_take;
    logic [3:0]  int_idx;
    logic [15:0] int_vector;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .xirq_n(xirq_n),
        .periph_req(periph_req), .core_imask(core_imask),
        .sense_we(sense_we), .sense_wdata(sense_wdata),
        .prio_we(prio_we), .prio_wdata(prio_wdata),
        .xmask_we(xmask_we), .xmask_wdata(xmask_wdata),
        .int_ack(int_ack), .int_take(int_take), .int_idx(int_idx),
        .int_vector(int_vector)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int exp_vec(input int idx);
        if (idx == 15) return 16'hFFF4;
        if (idx == 0)  return 16'hFFF2;
        return 16'hFFF0 - 2 * idx;
    endfunction

    task automatic expect_none(input string tag, input int n);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (int_take) seen = 1;
        end
        check(!seen, tag, seen, 0);
    endtask

    // wait for an offer, check index, vector, hold, then acknowledge
    task automatic take_offer(input string tag, input int idx);
        int n = 0;
        while (!int_take && n < 12) begin
            @(negedge clk);
            n++;
        end
        check(int_take == 1'b1, {tag, " take"}, int_take, 1);
        check(int_idx == idx, {tag, " idx"}, int_idx, idx);
        check(int_vector == exp_vec(idx), {tag, " R10 vector"}, int_vector, exp_vec(idx));
        tick(2);
        check(int_take && int_idx == idx, {tag, " R11 hold"}, int_idx, idx);
        int_ack = 1'b1;
        core_imask = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        check(!int_take, {tag, " R11 release"}, int_take, 0);
    endtask

    task automatic drain();
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (int_take) begin
                int_ack = 1'b1;
                @(negedge clk);
                int_ack = 1'b0;
            end
        end
    endtask

    task automatic write_prio(input logic [3:0] v);
        prio_wdata = v; prio_we = 1'b1;
        @(negedge clk);
        prio_we = 1'b0;
    endtask

    task automatic write_sense(input logic v);
        sense_wdata = v; sense_we = 1'b1;
        @(negedge clk);
        sense_we = 1'b0;
    endtask

    task automatic write_xmask(input logic v);
        xmask_wdata = v; xmask_we = 1'b1;
        @(negedge clk);
        xmask_we = 1'b0;
    endtask

    task automatic t_reset();
        check(int_take == 1'b0, "R1 take after reset", int_take, 0);
        xirq_n = 1'b0;
        core_imask = 1'b0;
        expect_none("R1 R8 nmi disabled after reset", 8);
        xirq_n = 1'b1;
        core_imask = 1'b1;
        tick(4);
    endtask

    task automatic t_mask();
        periph_req[2] = 1'b1;
        expect_none("R2 held while masked", 8);
        core_imask = 1'b0;
        take_offer("R2 taken when unmasked", 3);
        periph_req = '0;
        tick(2);
    endtask

    task automatic t_order();
        irq_n = 1'b0;
        periph_req[0] = 1'b1;
        periph_req[5] = 1'b1;
        tick(4);
        core_imask = 1'b0;
        take_offer("R3 R6 pin level first", 0);
        irq_n = 1'b1;
        tick(4);
        core_imask = 1'b0;
        take_offer("R3 code 1 next", 1);
        periph_req[0] = 1'b0;
        core_imask = 1'b0;
        take_offer("R3 code 6 last", 6);
        periph_req = '0;
        tick(2);
    endtask

    task automatic t_promote();
        write_prio(4'd5);
        irq_n = 1'b0;
        periph_req[0] = 1'b1;
        periph_req[4] = 1'b1;
        tick(4);
        core_imask = 1'b0;
        take_offer("R4 promoted code 5", 5);
        periph_req[4] = 1'b0;
        tick(1);
        write_prio(4'd15);
        core_imask = 1'b0;
        take_offer("R4 code 15 promotes nothing", 0);
        irq_n = 1'b1;
        periph_req = '0;
        tick(4);
    endtask

    task automatic t_locked();
        write_prio(4'd0);
        core_imask = 1'b0;
        write_prio(4'd7);
        core_imask = 1'b1;
        periph_req[6] = 1'b1;
        periph_req[2] = 1'b1;
        tick(1);
        core_imask = 1'b0;
        take_offer("R5 write ignored while unmasked", 3);
        periph_req = '0;
        tick(2);
    endtask

    task automatic t_edge();
        write_sense(1'b1);
        irq_n = 1'b0;
        tick(3);
        irq_n = 1'b1;
        expect_none("R2 edge latch held while masked", 6);
        core_imask = 1'b0;
        take_offer("R7 latched edge after pin high", 0);
        core_imask = 1'b0;
        expect_none("R7 latch cleared by ack", 8);
        core_imask = 1'b1;
        write_sense(1'b0);
        core_imask = 1'b0;
        expect_none("R6 level mode pin high idle", 6);
        core_imask = 1'b1;
    endtask

    task automatic t_nmi();
        xirq_n = 1'b0;
        write_xmask(1'b1);
        core_imask = 1'b0;
        expect_none("R8 write of 1 does not enable", 8);
        core_imask = 1'b1;
        irq_n = 1'b0;
        write_xmask(1'b0);
        take_offer("R9 nmi while masked", 15);
        core_imask = 1'b0;
        tick(1);
        take_offer("R9 nmi beats pin", 15);
        write_xmask(1'b1);
        irq_n = 1'b1;
        tick(1);
        take_offer("R8 write of 1 cannot disable", 15);
        xirq_n = 1'b1;
        core_imask = 1'b1;
        drain();
        expect_none("R9 idle after release", 6);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_mask();
        t_order();
        t_promote();
        t_locked();
        t_edge();
        t_nmi();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule